// File: doc/BRIEF.md
# Batched DDR Refresh Scheduler

This block decides when a DDR memory must be refreshed and generates the command stream for each refresh episode. Refreshes come in groups: once per batch interval, which spans four refresh periods, the scheduler raises a need-refresh request. While the request is high, the rest of the controller must forward the scheduler's command in place of its own traffic.

An episode runs in a fixed order. It first idles for a drain delay so that any write already in flight can finish and meet its recovery time. It then precharges all banks and waits a short settling time. It then issues a fixed number of auto-refresh commands, with a refresh-cycle wait after each one, and finally drops the request. The idle gap between episodes is shortened by the episode length, so one episode starts exactly once per batch interval.

A synchronous initialization hold-off input keeps the scheduler quiet while the memory is brought up. When the hold-off is released, the scheduler counts one full batch interval before the first episode. The hold-off also acts as the block's reset.

Top module: `rfsched_top`

## Requirements
- R1: While `initHold` is sampled high at a clock edge, `needRefresh` is low and `cmdCode` is NOP (4'b0111) from that edge on.
- R2: After `initHold` is released, `needRefresh` rises on the INTERVAL_CLKS-th rising edge at which `initHold` is sampled low, and not earlier.
- R3: With no hold-off in between, successive rising edges of `needRefresh` are exactly INTERVAL_CLKS cycles apart.
- R4: An episode starts with DRAIN_CLKS cycles of NOP while `needRefresh` is high. A single precharge-all follows: `cmdCode` 4'b0010 with `cmdAddr` bit 10 set and every other address bit clear.
- R5: After the precharge, PRE_WAIT_CLKS cycles of NOP pass before the first auto-refresh command (4'b0111 NOP, then 4'b0001 refresh).
- R6: Each episode contains exactly NUM_REFRESH auto-refresh commands (4'b0001), and each refresh comes RFC_CLKS+1 cycles after the one before it.
- R7: After the last refresh, RFC_CLKS cycles of NOP pass with `needRefresh` high, and then `needRefresh` falls.
- R8: Whenever `needRefresh` is low, `cmdCode` is NOP and `cmdAddr` is zero.
- R9: A command other than NOP appears on `cmdCode` only while `needRefresh` is high.
- R10: A hold-off during an episode aborts it at once. After release, the next episode again waits a full INTERVAL_CLKS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| initHold | input | 1 | Initialization hold-off; synchronous, also serves as reset |
| needRefresh | output | 1 | Refresh episode in progress; the command output has priority |
| cmdCode | output | 4 | Command as {csN, rasN, casN, weN} |
| cmdAddr | output | ADDR_W | Address bus for the command; bit 10 marks precharge-all |

## Verification
The main stimulus is a long run with no hold-off. It exposes the exact batch period and the position of every command inside an episode, so an off-by-one in any wait shows up as a shifted command.

Directed aborts in the middle of an episode tell a real restart apart from a resumed timer. Short random hold-off pulses at arbitrary phases check that release always restarts the full interval.

A bench-side position model predicts the command for every cycle. Separate gap and refresh-count measurements flag period drift and missing or extra refreshes independently of that model.

// File: rtl/rfsched_pkg.sv
package rfsched_pkg;
  localparam logic [3:0] CMD_NOP       = 4'b0111;
  localparam logic [3:0] CMD_PRECHARGE = 4'b0010;
  localparam logic [3:0] CMD_REFRESH   = 4'b0001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DRAIN, ST_PRE, ST_PREWAIT, ST_REF, ST_RFCWAIT
  } stepT;

  typedef enum logic [2:0] {
    LD_FIRST, LD_GAP, LD_DRAIN, LD_PREWAIT, LD_RFC, LD_ZERO
  } loadSelT;

  typedef struct packed {
    logic    load;
    loadSelT sel;
    logic    issuePre;
    logic    issueRef;
  } strobeT;
endpackage

// File: rtl/rfsched_ctrl.sv
module rfsched_ctrl
  import rfsched_pkg::*;
#(
  parameter int NUM_REFRESH = 4
) (
  input  logic   clk,
  input  logic   initHold,
  input  logic   cntZero,
  output strobeT strb,
  output logic   needRefresh
);
  localparam int RW = (NUM_REFRESH > 1) ? $clog2(NUM_REFRESH) : 1;
  localparam logic [RW-1:0] LAST_REF = RW'(NUM_REFRESH - 1);

  stepT          state, stateNext;
  logic [RW-1:0] refIdx, refIdxNext;

  always_comb begin
    stateNext     = state;
    refIdxNext    = refIdx;
    strb.load     = 1'b0;
    strb.sel      = LD_ZERO;
    strb.issuePre = 1'b0;
    strb.issueRef = 1'b0;
    if (initHold) begin
      stateNext  = ST_IDLE;
      refIdxNext = '0;
      strb.load  = 1'b1;
      strb.sel   = LD_FIRST;
    end else begin
      unique case (state)
        ST_IDLE: if (cntZero) begin
          stateNext = ST_DRAIN;
          strb.load = 1'b1;
          strb.sel  = LD_DRAIN;
        end
        ST_DRAIN: if (cntZero) begin
          stateNext = ST_PRE;
          strb.load = 1'b1;
          strb.sel  = LD_ZERO;
        end
        ST_PRE: begin
          strb.issuePre = 1'b1;
          refIdxNext    = '0;
          stateNext     = ST_PREWAIT;
          strb.load     = 1'b1;
          strb.sel      = LD_PREWAIT;
        end
        ST_PREWAIT: if (cntZero) begin
          stateNext = ST_REF;
          strb.load = 1'b1;
          strb.sel  = LD_ZERO;
        end
        ST_REF: begin
          strb.issueRef = 1'b1;
          stateNext     = ST_RFCWAIT;
          strb.load     = 1'b1;
          strb.sel      = LD_RFC;
        end
        ST_RFCWAIT: if (cntZero) begin
          strb.load = 1'b1;
          if (refIdx == LAST_REF) begin
            stateNext = ST_IDLE;
            strb.sel  = LD_GAP;
          end else begin
            refIdxNext = refIdx + 1'b1;
            stateNext  = ST_REF;
            strb.sel   = LD_ZERO;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state  <= stateNext;
    refIdx <= refIdxNext;
  end

  assign needRefresh = (state != ST_IDLE);

  // R1: hold-off silences the request on the following cycle
  p_hold_quiet_r1: assert property (@(posedge clk)
    initHold |=> !needRefresh);

  // R4: the first cycle of an episode is a drain cycle, not a command
  p_drain_first_r4: assert property (@(posedge clk) disable iff (initHold)
    $rose(needRefresh) |-> (!strb.issuePre && !strb.issueRef));

  // R5: precharge is never immediately followed by a refresh
  p_pre_gap_r5: assert property (@(posedge clk) disable iff (initHold)
    strb.issuePre |=> !strb.issueRef);

  // R6: refreshes are never back to back
  p_ref_isolated_r6: assert property (@(posedge clk) disable iff (initHold)
    strb.issueRef |=> (!strb.issueRef && needRefresh));
endmodule

// File: rtl/rfsched_dp.sv
module rfsched_dp
  import rfsched_pkg::*;
#(
  parameter int INTERVAL_CLKS = 6240,
  parameter int RFC_CLKS      = 320,
  parameter int DRAIN_CLKS    = 10,
  parameter int PRE_WAIT_CLKS = 2,
  parameter int NUM_REFRESH   = 4,
  parameter int ADDR_W        = 14
) (
  input  logic              clk,
  input  strobeT            strb,
  output logic              cntZero,
  output logic [3:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr
);
  localparam int EPISODE = DRAIN_CLKS + 1 + PRE_WAIT_CLKS + NUM_REFRESH * (RFC_CLKS + 1);
  localparam int GAP     = INTERVAL_CLKS - EPISODE;
  localparam int CW      = $clog2(INTERVAL_CLKS + 1);
  localparam int ALL_BIT = 10;

  localparam logic [CW-1:0] V_FIRST = CW'(INTERVAL_CLKS - 1);
  localparam logic [CW-1:0] V_GAP   = CW'(GAP - 1);
  localparam logic [CW-1:0] V_DRAIN = CW'(DRAIN_CLKS - 1);
  localparam logic [CW-1:0] V_PW    = CW'(PRE_WAIT_CLKS - 1);
  localparam logic [CW-1:0] V_RFC   = CW'(RFC_CLKS - 1);

  logic [CW-1:0] cnt, loadVal;

  always_comb begin
    unique case (strb.sel)
      LD_FIRST:   loadVal = V_FIRST;
      LD_GAP:     loadVal = V_GAP;
      LD_DRAIN:   loadVal = V_DRAIN;
      LD_PREWAIT: loadVal = V_PW;
      LD_RFC:     loadVal = V_RFC;
      default:    loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.load)  cnt <= loadVal;
    else if (!cntZero) cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_comb begin
    cmdCode = CMD_NOP;
    cmdAddr = '0;
    if (strb.issuePre) begin
      cmdCode          = CMD_PRECHARGE;
      cmdAddr[ALL_BIT] = 1'b1;
    end else if (strb.issueRef) begin
      cmdCode = CMD_REFRESH;
    end
  end

  // R6: a refresh always starts a fresh tRFC wait, never a zero count
  p_ref_loads_wait_r6: assert property (@(posedge clk)
    strb.issueRef |=> (cnt == V_RFC));
endmodule

// File: rtl/rfsched_top.sv
module rfsched_top
  import rfsched_pkg::*;
#(
  parameter int INTERVAL_CLKS = 6240,
  parameter int RFC_CLKS      = 320,
  parameter int DRAIN_CLKS    = 10,
  parameter int PRE_WAIT_CLKS = 2,
  parameter int NUM_REFRESH   = 4,
  parameter int ADDR_W        = 14
) (
  input  logic              clk,
  input  logic              initHold,
  output logic              needRefresh,
  output logic [3:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr
);
  strobeT strb;
  logic   cntZero;

  rfsched_ctrl #(.NUM_REFRESH(NUM_REFRESH)) uCtrl (
    .clk(clk), .initHold(initHold), .cntZero(cntZero),
    .strb(strb), .needRefresh(needRefresh)
  );

  rfsched_dp #(
    .INTERVAL_CLKS(INTERVAL_CLKS), .RFC_CLKS(RFC_CLKS), .DRAIN_CLKS(DRAIN_CLKS),
    .PRE_WAIT_CLKS(PRE_WAIT_CLKS), .NUM_REFRESH(NUM_REFRESH), .ADDR_W(ADDR_W)
  ) uDp (
    .clk(clk), .strb(strb), .cntZero(cntZero),
    .cmdCode(cmdCode), .cmdAddr(cmdAddr)
  );

  // R8: outside an episode only NOP leaves the block
  p_nop_idle_r8: assert property (@(posedge clk) disable iff (initHold)
    !needRefresh |-> (cmdCode == CMD_NOP && cmdAddr == '0));

  // R7: the request drops only after a NOP wait cycle
  p_fall_after_wait_r7: assert property (@(posedge clk) disable iff (initHold)
    $fell(needRefresh) |-> ($past(cmdCode) == CMD_NOP));
endmodule

// File: tb/tb_rfsched_top.sv
module tb_rfsched_top;
  localparam int T_INT   = 200;
  localparam int T_RFC   = 20;
  localparam int T_DRAIN = 10;
  localparam int T_PW    = 2;
  localparam int NREF    = 4;
  localparam int AW      = 14;
  localparam int EPI     = T_DRAIN + 1 + T_PW + NREF * (T_RFC + 1);

  logic          clk = 1'b0;
  logic          initHold;
  logic          needRefresh;
  logic [3:0]    cmdCode;
  logic [AW-1:0] cmdAddr;

  always #4 clk = ~clk;

  rfsched_top #(
    .INTERVAL_CLKS(T_INT), .RFC_CLKS(T_RFC), .DRAIN_CLKS(T_DRAIN),
    .PRE_WAIT_CLKS(T_PW), .NUM_REFRESH(NREF), .ADDR_W(AW)
  ) dut (
    .clk(clk), .initHold(initHold), .needRefresh(needRefresh),
    .cmdCode(cmdCode), .cmdAddr(cmdAddr)
  );

  int checks = 0, fails = 0;
  int nLow = 0, cycleIdx = 0, lastRise = -1, refCnt = 0;
  bit prevNr = 0, episodeClean = 0, abortTag = 0, done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycleIdx);
    end
  endtask

  // phase: 0 first wait, 1 gap, 2 drain, 3 precharge, 4 settle, 5 refresh, 6 tRFC wait
  function automatic int phaseOf(int n);
    int q, r;
    if (n < T_INT) return 0;
    q = (n - T_INT) % T_INT;
    if (q >= EPI) return 1;
    if (q < T_DRAIN) return 2;
    if (q == T_DRAIN) return 3;
    if (q <= T_DRAIN + T_PW) return 4;
    r = q - (T_DRAIN + 1 + T_PW);
    return (r % (T_RFC + 1) == 0) ? 5 : 6;
  endfunction

  function automatic int expCmd(int ph);
    if (ph == 3) return 4'b0010;
    if (ph == 5) return 4'b0001;
    return 4'b0111;
  endfunction

  function automatic string tagOf(int ph, bit h, bit ab);
    if (h) return "R1";
    if (ab) return "R10";
    case (ph)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic stepCycle(bit h);
    int ph, ec, ea;
    string tg;
    initHold = h;
    @(posedge clk);
    if (h) nLow = 0; else nLow++;
    @(negedge clk);
    cycleIdx++;
    ph = phaseOf(nLow);
    if (h) ph = 0;
    ec = expCmd(ph);
    ea = (ph == 3) ? (1 << 10) : 0;
    tg = tagOf(ph, h, abortTag);
    check(needRefresh == (ph >= 2), tg, needRefresh, (ph >= 2) ? 1 : 0);
    check(cmdCode == ec[3:0], tg, cmdCode, ec);
    check(cmdAddr == ea[AW-1:0], (ph < 2) ? "R8" : tg, cmdAddr, ea);
    // R9: commands only under the request
    check(cmdCode == 4'b0111 || needRefresh, "R9", cmdCode, 4'b0111);
    if (h) begin
      episodeClean = 0;
      lastRise = -1;
    end
    if (needRefresh && !prevNr) begin
      if (lastRise >= 0) check(cycleIdx - lastRise == T_INT, "R3", cycleIdx - lastRise, T_INT);
      lastRise = cycleIdx;
      refCnt = 0;
      episodeClean = 1;
      abortTag = 0;
    end
    if (cmdCode == 4'b0001) refCnt++;
    if (!needRefresh && prevNr && episodeClean)
      check(refCnt == NREF, "R6", refCnt, NREF);
    prevNr = needRefresh;
  endtask

  initial begin
    int holdLeft;
    void'($urandom(32'd2024));
    initHold = 1'b1;
    // R1: reset state under hold-off
    repeat (3) stepCycle(1);
    // R2, R3: clean run over several periods
    repeat (4 * T_INT + 20) stepCycle(0);
    // R10: abort in the refresh part of an episode
    while (!needRefresh) stepCycle(0);
    repeat (T_DRAIN + T_PW + 5) stepCycle(0);
    abortTag = 1;
    stepCycle(1);
    repeat (T_INT + EPI + 5) stepCycle(0);
    // R10: abort in the drain part
    while (!needRefresh) stepCycle(0);
    abortTag = 1;
    stepCycle(1);
    stepCycle(1);
    abortTag = 1;
    repeat (2 * T_INT) stepCycle(0);
    abortTag = 0;
    // random hold-off pulses at arbitrary phases
    holdLeft = 0;
    for (int i = 0; i < 4000; i++) begin
      if (holdLeft == 0 && $urandom_range(0, 299) == 0) holdLeft = $urandom_range(1, 4);
      if (holdLeft > 0) begin
        holdLeft--;
        stepCycle(1);
      end else begin
        stepCycle(0);
      end
    end
    repeat (3 * T_INT) stepCycle(0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycleIdx, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule